// File: doc/BRIEF.md
# Periodic Battery Health Tester

This block schedules load tests of a backup battery and keeps a latched warning when the battery is found weak. While the main supply is valid, it connects a test load for a fixed number of clock cycles and watches a digitised comparator that reports whether the battery sits below its trip level. A test runs once after every power-up, started by the recovery-done pulse from the supply supervisor. After that, tests repeat after a long idle interval.

The warning is latched. Later periodic tests cannot clear it, but every power-up test evaluates it again, so a replaced or recovered battery clears it on the next power cycle. When the supply fails, the block drops the load at once, abandons any test in progress and restarts its timing from the next power-up. The interval and the test length are clock-count parameters, so a simulation can use short values.

Top module: `batt_health_tester`

## Requirements
- R1: After reset `load_en_o` is 0 and `warn_n_o` is 1. On `warn_n_o`, 0 means the open-drain pin sinks (warning active) and 1 means the pin is released (no warning).
- R2: With `supply_ok_i` high, a recovery pulse sampled on `recov_done_i` starts a power-up test. `load_en_o` is 1 from the next cycle for exactly `PULSE_CYCLES` cycles. This test runs even when the warning is already active.
- R3: No test starts before a recovery pulse. A recovery pulse that arrives while `supply_ok_i` is low is ignored.
- R4: After a test completes, `load_en_o` stays 0 for exactly `PERIOD_CYCLES` cycles and then a periodic test of `PULSE_CYCLES` cycles starts. This repeats while the supply stays valid.
- R5: If `batt_low_i` is sampled high on any clock edge while the load is enabled, including the last one, `warn_n_o` goes to 0 in the cycle after the load drops.
- R6: `batt_low_i` is ignored while the load is not enabled.
- R7: A periodic test that finds the battery good leaves an active warning active.
- R8: A power-up test that finds the battery good clears the warning. `warn_n_o` returns to 1 when the load drops.
- R9: When `supply_ok_i` goes low, `load_en_o` drops in the same cycle and any test in progress is aborted with the warning unchanged. The period timer restarts, so the next periodic test follows `PERIOD_CYCLES` after the next power-up test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supply_ok_i | input | 1 | Main supply within tolerance |
| recov_done_i | input | 1 | One-cycle pulse from the supervisor when its recovery interval ends |
| batt_low_i | input | 1 | Synchronised comparator output, 1 when the battery is below the trip level |
| load_en_o | output | 1 | Connects the test load to the battery |
| warn_n_o | output | 1 | Battery warning, active low, 0 = drive the open-drain pin low |

## Verification
The bench puts a low-battery reading on the first and on the last cycle of the load window. A design with an off-by-one sampling window would miss one of the two and keep the warning released. It holds `batt_low_i` high through the idle gap, so a design that samples the comparator outside the window would latch a false warning. It also checks the exact length of the idle gap, and after a power-up test it checks that the period restarts from that test; a counter that paused instead of restarting would start the next test early. A test is aborted after a low reading has already been seen, which catches a design that commits the partial result. Good-battery tests are run in both periodic and power-up form, which separates the sticky case from the clearing case.

// File: rtl/bht_pkg.sv
package bht_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TEST = 2'd1,
    ST_WAIT = 2'd2
  } bht_state_e;
endpackage

// File: rtl/bht_cycle_cnt.sv
module bht_cycle_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/bht_warn_latch.sv
module bht_warn_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sample_i,
  input  logic finish_i,
  input  logic powerup_i,
  output logic warn_o
);
  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seen_q <= 1'b0;
    else if (start_i)  seen_q <= 1'b0;
    else if (sample_i) seen_q <= 1'b1;
  end

  // sticky set; only a power-up test may release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warn_o <= 1'b0;
    else if (finish_i) begin
      if (seen_q || sample_i) warn_o <= 1'b1;
      else if (powerup_i)     warn_o <= 1'b0;
    end
  end
endmodule

// File: rtl/batt_health_tester.sv
module batt_health_tester
  import bht_pkg::*;
#(
  parameter int PERIOD_CYCLES = 86_400_000,
  parameter int PULSE_CYCLES  = 1_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic recov_done_i,
  input  logic batt_low_i,
  output logic load_en_o,
  output logic warn_n_o
);
  localparam int MAX_CNT = (PERIOD_CYCLES > PULSE_CYCLES) ? PERIOD_CYCLES : PULSE_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYCLES - 1);
  localparam logic [CNT_W-1:0] PERIOD_LAST = CNT_W'(PERIOD_CYCLES - 1);

  bht_state_e       state_q, state_d;
  logic             pu_q, pu_d;
  logic             cnt_clr, test_start, test_done;
  logic [CNT_W-1:0] cnt;
  logic             in_test, warn;

  always_comb begin
    state_d    = state_q;
    pu_d       = pu_q;
    cnt_clr    = 1'b0;
    test_start = 1'b0;
    test_done  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        cnt_clr = 1'b1;
        if (supply_ok_i && recov_done_i) begin
          state_d    = ST_TEST;
          test_start = 1'b1;
          pu_d       = 1'b1;
        end
      end
      ST_TEST: begin
        if (!supply_ok_i) begin
          state_d = ST_OFF;
          cnt_clr = 1'b1;
        end else if (cnt == PULSE_LAST) begin
          state_d   = ST_WAIT;
          cnt_clr   = 1'b1;
          test_done = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!supply_ok_i) begin
          state_d = ST_OFF;
          cnt_clr = 1'b1;
        end else if (cnt == PERIOD_LAST) begin
          state_d    = ST_TEST;
          cnt_clr    = 1'b1;
          test_start = 1'b1;
          pu_d       = 1'b0;
        end
      end
      default: begin
        state_d = ST_OFF;
        cnt_clr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      pu_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pu_q    <= pu_d;
    end
  end

  bht_cycle_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .en_i   (1'b1),
    .cnt_o  (cnt)
  );

  // supply gate drops the load in the failing cycle
  assign in_test = (state_q == ST_TEST) && supply_ok_i;

  bht_warn_latch u_warn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (test_start),
    .sample_i  (in_test && batt_low_i),
    .finish_i  (test_done),
    .powerup_i (pu_q),
    .warn_o    (warn)
  );

  assign load_en_o = in_test;
  assign warn_n_o  = ~warn;
endmodule

// File: rtl/bht_checker.sv
module bht_checker #(
  parameter int PULSE_CYCLES = 1_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic recov_done_i,
  input logic batt_low_i,
  input logic load_en_o,
  input logic warn_n_o
);
  localparam int RW = $clog2(PULSE_CYCLES + 2);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= '0;
    else if (load_en_o) run_q <= run_q + 1'b1;
    else               run_q <= '0;
  end

  a_r2_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en_o |-> (run_q < RW'(PULSE_CYCLES)));

  a_r3_load_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(load_en_o) |-> $past(supply_ok_i));

  a_r5_set_after_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(warn_n_o) |-> $past(load_en_o));

  a_r8_clear_after_good_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warn_n_o) |-> ($past(load_en_o) && !$past(batt_low_i)));

  a_r9_hold_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> $stable(warn_n_o));

  a_r6_no_warn_change_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_en_o) |-> $stable(warn_n_o));
endmodule

bind batt_health_tester bht_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_bht_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .supply_ok_i  (supply_ok_i),
  .recov_done_i (recov_done_i),
  .batt_low_i   (batt_low_i),
  .load_en_o    (load_en_o),
  .warn_n_o     (warn_n_o)
);

// File: tb/batt_health_tester_test.sv
`timescale 1ns/1ps
module batt_health_tester_test;
  localparam int PERIOD = 40;
  localparam int PULSE  = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0;
  logic recov_done = 1'b0;
  logic batt_low = 1'b0;
  logic load_en, warn_n;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  batt_health_tester #(.PERIOD_CYCLES(PERIOD), .PULSE_CYCLES(PULSE)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .supply_ok_i  (supply_ok),
    .recov_done_i (recov_done),
    .batt_low_i   (batt_low),
    .load_en_o    (load_en),
    .warn_n_o     (warn_n)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_pulse(input int low_idx);
    for (int i = 0; i < PULSE; i++) begin
      chk(load_en, 1'b1, "R2 load held");
      batt_low = (i == low_idx);
      step();
    end
    batt_low = 1'b0;
    chk(load_en, 1'b0, "R2 load ends");
  endtask

  task automatic check_gap(input logic noise);
    for (int i = 0; i < PERIOD; i++) begin
      chk(load_en, 1'b0, "R4 gap");
      batt_low = noise;
      step();
    end
    batt_low = 1'b0;
    chk(load_en, 1'b1, "R4 periodic start");
  endtask

  task automatic power_up();
    supply_ok = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(load_en, 1'b0, "R3 waits for recovery");
    end
    recov_done = 1'b1;
    step();
    recov_done = 1'b0;
    chk(load_en, 1'b1, "R2 power-up test starts");
  endtask

  task automatic t_reset();
    step(); step();
    rst_ni = 1'b1;
    step();
    chk(load_en, 1'b0, "R1 load");
    chk(warn_n, 1'b1, "R1 warn released");
  endtask

  task automatic t_recov_without_supply();
    recov_done = 1'b1;
    step();
    recov_done = 1'b0;
    step();
    chk(load_en, 1'b0, "R3 recovery ignored without supply");
  endtask

  task automatic t_first_test_good();
    power_up();
    run_pulse(-1);
    chk(warn_n, 1'b1, "R2 good battery no warning");
  endtask

  task automatic t_noise_then_low_first();
    check_gap(1'b1);
    chk(warn_n, 1'b1, "R6 idle low reading ignored");
    run_pulse(0);
    chk(warn_n, 1'b0, "R5 low on first load cycle");
  endtask

  task automatic t_sticky();
    check_gap(1'b0);
    run_pulse(-1);
    chk(warn_n, 1'b0, "R7 periodic good test keeps warning");
  endtask

  task automatic t_powerup_clears();
    supply_ok = 1'b0;
    step();
    chk(load_en, 1'b0, "R9 idle off");
    step();
    power_up();
    run_pulse(-1);
    chk(warn_n, 1'b1, "R8 power-up good test clears");
  endtask

  task automatic t_abort();
    check_gap(1'b0);
    for (int i = 0; i < 3; i++) begin
      batt_low = (i == 1);
      step();
    end
    batt_low = 1'b0;
    chk(load_en, 1'b1, "R9 test in progress");
    supply_ok = 1'b0;
    #1;
    chk(load_en, 1'b0, "R9 load drops at once");
    for (int i = 0; i < 5; i++) step();
    chk(warn_n, 1'b1, "R9 abort leaves warning unchanged");
    chk(load_en, 1'b0, "R9 stays off");
  endtask

  task automatic t_low_last_cycle();
    power_up();
    run_pulse(PULSE - 1);
    chk(warn_n, 1'b0, "R5 low on last load cycle");
    check_gap(1'b0);
    run_pulse(-1);
    chk(warn_n, 1'b0, "R7 still sticky");
  endtask

  initial begin
    t_reset();
    t_recov_without_supply();
    t_first_test_good();
    t_noise_then_low_first();
    t_sticky();
    t_powerup_clears();
    check_gap(1'b0);  // R9 period timed from power-up test
    run_pulse(-1);
    t_abort();
    t_low_last_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule